// File: doc/BRIEF.md
# Dual-Channel Converter Serial Register Front End

This block is the digital side of a two-channel 12-bit converter. A host writes 16-bit words over a three-wire serial port: an active-low frame strobe, a serial clock and a data line. A fourth line returns data, either as readback or as a pass-through so that several devices can be chained. Each word carries a 4-bit command in its top bits and a 12-bit value in its lower bits. Write commands fill one of two input registers. The input registers are then copied into the two converter code registers. The copy happens either when an active-low update pin falls, or automatically while that pin is held low.

All serial pins are oversampled by the block's system clock through a synchronizer, so the port runs in a single clock domain. The serial clock must therefore be much slower than the system clock. The sampling edge of the serial clock, the clear target and chained operation are all set through a configuration command. An active-low clear pin forces both register stages of both channels to zero scale or to midscale. The code registers are presented as plain 12-bit outputs.

Top module: `dac_serial_front`

## Requirements
- R1: After reset both code outputs are 12'h000 and ser_dout is 0. Data is sampled on the falling serial clock edge, the clear target is zero scale and chaining is off.
- R2: A word is sent MSB first. Bits [15:12] are the command and bits [11:0] are the value. Command 1 writes input register A, 2 writes input register B, 3 reads back code A, 4 reads back code B. Command 5 configures the block: value bit 0 set means sample on the rising edge, bit 1 set means clear to midscale, bit 2 set means chained mode.
- R3: In standalone mode a word is acted on at the 16th sampling edge while frame_n is low. Later edges in the same frame are ignored.
- R4: In standalone mode, raising frame_n before the 16th sampling edge discards the partial word, and no register changes.
- R5: While upd_n is high, writes change only the input registers. A falling edge on upd_n copies both input registers into both code registers.
- R6: While upd_n is low, a write updates the code outputs with no pulse. In standalone mode this happens at the 16th sampling edge, before frame_n rises.
- R7: With configuration bit 0 set, data is taken on the rising serial clock edge instead of the falling one.
- R8: ser_dout changes only on the serial clock edge opposite the sampling edge. After a readback command, the next frame's first 16 opposite edges drive {4'b0000, code} MSB first.
- R9: While clear_n is low, both input and code registers hold 12'h000, or 12'h800 when configuration bit 1 is set. Configuration is not cleared.
- R10: In chained mode every sampled bit appears on ser_dout 16 sampling edges later. The last 16 bits are decoded only when frame_n rises. A frame of fewer than 16 edges is discarded.
- R11: Commands 0 and 6 through 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low word frame strobe |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data in |
| upd_n | input | 1 | Active-low update strobe; held low selects automatic update |
| clear_n | input | 1 | Active-low clear |
| ser_dout | output | 1 | Serial data out for readback and chaining |
| code_a | output | 12 | Code register of channel A |
| code_b | output | 12 | Code register of channel B |

## Verification
A pin change passes through SYNC_STAGES synchronizer flops and is edge-detected. It acts on the next clock, so the code registers and ser_dout settle by SYNC_STAGES+1 clocks after the pin moves. A readback load adds one more clock. The bench holds every serial clock phase, update pulse and clear pulse for 10 clocks, and samples at falling clock edges 10 clocks after the last stimulus. Each result is therefore read well past its due cycle and before the next pin change. To tell the two edges apart, the data line carries the inverted bit before the opposite edge and the true bit only before the sampling edge. ser_dout is read between those two edges.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   localparam int unsigned NUM_CH = 2;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'h0,
      CMD_WR_A = 4'h1,
      CMD_WR_B = 4'h2,
      CMD_RD_A = 4'h3,
      CMD_RD_B = 4'h4,
      CMD_CFG  = 4'h5
   } cmd_e;

   // bit 2: chained, bit 1: midscale clear, bit 0: rising-edge sampling
   typedef struct packed {
      logic daisy;
      logic clr_mid;
      logic rise;
   } cfg_t;

endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
   parameter int unsigned  W       = 1,
   parameter int unsigned  STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned CHAIN_W = W * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("dsf_sync needs at least two stages");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/dsf_shifter.sv
module dsf_shifter #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_q,
   input  logic              sclk_q,
   input  logic              din_q,
   input  logic              rise_sel,
   input  logic              daisy,
   input  logic              ld_en,
   input  logic [WORD_W-1:0] ld_word,
   output logic              dout,
   output logic              word_stb,
   output logic [WORD_W-1:0] word,
   output logic              opp_edge,
   output logic [CNT_W-1:0]  bit_cnt
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   logic              sclk_d, frame_d;
   logic [WORD_W-1:0] shreg;
   logic              in_frame, sclk_up, sclk_dn, act_edge, shift_ok, full;
   logic              frame_start, frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         frame_d <= 1'b1;
      end else begin
         sclk_d  <= sclk_q;
         frame_d <= frame_q;
      end
   end

   assign in_frame    = ~frame_q;
   assign sclk_up     = sclk_q & ~sclk_d;
   assign sclk_dn     = ~sclk_q & sclk_d;
   assign act_edge    = in_frame & (rise_sel ? sclk_up : sclk_dn);
   assign opp_edge    = in_frame & (rise_sel ? sclk_dn : sclk_up);
   assign frame_start = ~frame_q & frame_d;
   assign frame_end   = frame_q & ~frame_d;
   assign full        = (bit_cnt == CNT_FULL);
   assign shift_ok    = act_edge & (daisy | ~full) & ~frame_start;

   // standalone words complete on the last edge; chained words on frame end
   assign word     = daisy ? shreg : {shreg[WORD_W-2:0], din_q};
   assign word_stb = daisy ? (frame_end & full)
                           : (shift_ok & (bit_cnt == CNT_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else begin
         if (frame_start) begin
            bit_cnt <= '0;
         end else if (shift_ok) begin
            shreg <= {shreg[WORD_W-2:0], din_q};
            if (!full) bit_cnt <= bit_cnt + 1'b1;
         end
         if (ld_en) shreg <= ld_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dout <= 1'b0;
      else if (opp_edge) dout <= shreg[WORD_W-1];
   end
endmodule

// File: rtl/dsf_regs.sv
module dsf_regs
   import dsf_pkg::*;
#(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned CMD_W  = 4,
   parameter int unsigned WORD_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          word_stb,
   input  logic [WORD_W-1:0]             word,
   input  logic                          upd_q,
   input  logic                          clr_q,
   output cfg_t                          cfg,
   output logic [NUM_CH-1:0][DATA_W-1:0] code,
   output logic                          rb_en,
   output logic [WORD_W-1:0]             rb_word
);
   localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
   localparam int unsigned       PAD_W    = WORD_W - DATA_W;

   cmd_e              cmd;
   logic [DATA_W-1:0] value, clr_val;
   logic [NUM_CH-1:0] wr_hit;
   logic              rd_hit, rd_ch, cfg_hit, upd_d, upd_fall, auto_upd;

   assign cmd      = cmd_e'(word[WORD_W-1 -: CMD_W]);
   assign value    = word[DATA_W-1:0];
   assign clr_val  = cfg.clr_mid ? MIDSCALE : '0;
   assign upd_fall = ~upd_q & upd_d;
   assign auto_upd = ~upd_q & word_stb;

   always_comb begin
      wr_hit  = '0;
      rd_hit  = 1'b0;
      rd_ch   = 1'b0;
      cfg_hit = 1'b0;
      if (word_stb) begin
         case (cmd)
            CMD_WR_A: wr_hit[0] = 1'b1;
            CMD_WR_B: wr_hit[1] = 1'b1;
            CMD_RD_A: rd_hit    = 1'b1;
            CMD_RD_B: begin
               rd_hit = 1'b1;
               rd_ch  = 1'b1;
            end
            CMD_CFG:  cfg_hit   = 1'b1;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= '0;
         upd_d <= 1'b1;
      end else begin
         upd_d <= upd_q;
         if (cfg_hit) cfg <= cfg_t'(value[2:0]);
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DATA_W-1:0] in_r, in_nxt;

      assign in_nxt = wr_hit[ch] ? value : in_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_r     <= '0;
            code[ch] <= '0;
         end else if (!clr_q) begin
            in_r     <= clr_val;
            code[ch] <= clr_val;
         end else begin
            in_r <= in_nxt;
            if (upd_fall || auto_upd) code[ch] <= in_nxt;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_en   <= 1'b0;
         rb_word <= '0;
      end else begin
         rb_en <= rd_hit;
         if (rd_hit) rb_word <= {{PAD_W{1'b0}}, code[rd_ch]};
      end
   end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
   import dsf_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned CMD_W       = 4,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              upd_n,
   input  logic              clear_n,
   output logic              ser_dout,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b
);
   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam int unsigned PIN_W = 5;

   if (WORD_W != CMD_W + DATA_W) begin : g_bad_word
      $error("word width must equal command plus data width");
   end
   if (CMD_W != 4) begin : g_bad_cmd
      $error("command field must be four bits");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("data field too narrow for the configuration bits");
   end

   logic [PIN_W-1:0]              pins_q;
   logic                          frame_q, sclk_q, din_q, upd_q, clr_q;
   cfg_t                          cfg;
   logic                          word_stb, rb_en, opp_edge;
   logic [WORD_W-1:0]             word, rb_word;
   logic [CNT_W-1:0]              bit_cnt;
   logic [NUM_CH-1:0][DATA_W-1:0] code;

   dsf_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({frame_n, ser_clk, ser_din, upd_n, clear_n}),
      .q     (pins_q)
   );

   assign {frame_q, sclk_q, din_q, upd_q, clr_q} = pins_q;

   dsf_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_q  (frame_q),
      .sclk_q   (sclk_q),
      .din_q    (din_q),
      .rise_sel (cfg.rise),
      .daisy    (cfg.daisy),
      .ld_en    (rb_en),
      .ld_word  (rb_word),
      .dout     (ser_dout),
      .word_stb (word_stb),
      .word     (word),
      .opp_edge (opp_edge),
      .bit_cnt  (bit_cnt)
   );

   dsf_regs #(.DATA_W(DATA_W), .CMD_W(CMD_W), .WORD_W(WORD_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_stb (word_stb),
      .word     (word),
      .upd_q    (upd_q),
      .clr_q    (clr_q),
      .cfg      (cfg),
      .code     (code),
      .rb_en    (rb_en),
      .rb_word  (rb_word)
   );

   assign code_a = code[0];
   assign code_b = code[1];
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_q,
   input logic              clr_q,
   input logic              opp_edge,
   input logic              ser_dout,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [DATA_W-1:0] code_a,
   input logic [DATA_W-1:0] code_b
);
   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   // R1: first cycle out of reset shows zero codes and a low data out
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (code_a == '0) && (code_b == '0) && !ser_dout);

   // R5: no update strobe and no clear means the codes hold
   a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q && clr_q |=> $stable(code_a) && $stable(code_b));

   // R9: clear drives both channels to one of the two legal targets
   a_r9_clear_target: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_q |=> (code_a == code_b) && ((code_a == '0) || (code_a == MID)));

   // R8: data out moves only after an opposite serial edge
   a_r8_dout_opposite_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !opp_edge |=> $stable(ser_dout));

   // R3: the bit counter never runs past one word
   a_r3_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(WORD_W));
endmodule

bind dac_serial_front dsf_checker #(
   .DATA_W (DATA_W),
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .upd_q    (upd_q),
   .clr_q    (clr_q),
   .opp_edge (opp_edge),
   .ser_dout (ser_dout),
   .bit_cnt  (bit_cnt),
   .code_a   (code_a),
   .code_b   (code_b)
);

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
   localparam int HOLD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
   logic        upd_n = 1'b1, clear_n = 1'b1;
   logic        ser_dout;
   logic [11:0] code_a, code_b;
   int          n_chk = 0, n_fail = 0;
   bit          rise_mode = 1'b0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dac_serial_front dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
      .ser_din(ser_din), .upd_n(upd_n), .clear_n(clear_n),
      .ser_dout(ser_dout), .code_a(code_a), .code_b(code_b)
   );

   task automatic pause(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // sends the low n bits of v MSB first; wrong value before the opposite edge
   task automatic send_bits(input logic [31:0] v, input int n, input bit keep_open,
                            output logic [31:0] cap);
      cap = '0;
      ser_clk = rise_mode;
      pause(HOLD);
      frame_n = 1'b0;
      pause(HOLD);
      for (int i = n - 1; i >= 0; i--) begin
         ser_din = ~v[i];
         pause(HOLD);
         ser_clk = ~ser_clk;
         pause(HOLD);
         cap = {cap[30:0], ser_dout};
         ser_din = v[i];
         pause(HOLD);
         ser_clk = ~ser_clk;
         pause(HOLD);
      end
      if (!keep_open) close_frame();
   endtask

   task automatic close_frame();
      frame_n = 1'b1;
      pause(HOLD);
   endtask

   task automatic send(input logic [15:0] w);
      logic [31:0] cap;
      send_bits({16'h0, w}, 16, 1'b0, cap);
   endtask

   task automatic pulse_upd();
      upd_n = 1'b0;
      pause(HOLD);
      upd_n = 1'b1;
      pause(HOLD);
   endtask

   task automatic read_back(input logic [15:0] rd_cmd, output logic [15:0] got);
      logic [31:0] cap;
      send(rd_cmd);
      send_bits(32'h0, 16, 1'b0, cap);
      got = cap[15:0];
   endtask

   task automatic t_reset();
      chk("R1", "code_a", code_a, 12'h000);
      chk("R1", "code_b", code_b, 12'h000);
      chk("R1", "ser_dout", ser_dout, 1'b0);
   endtask

   task automatic t_write_hold();
      upd_n = 1'b1;
      pause(HOLD);
      send(16'h15A3);
      send(16'h20C7);
      chk("R5", "code_a before strobe", code_a, 12'h000);
      chk("R5", "code_b before strobe", code_b, 12'h000);
      pulse_upd();
      chk("R2 R5", "code_a after strobe", code_a, 12'h5A3);
      chk("R2 R5", "code_b after strobe", code_b, 12'h0C7);
   endtask

   task automatic t_auto();
      upd_n = 1'b0;
      pause(HOLD);
      send(16'h1123);
      chk("R6", "code_a auto", code_a, 12'h123);
   endtask

   task automatic t_partial();
      logic [31:0] cap;
      upd_n = 1'b1;
      pause(HOLD);
      send_bits(32'h0000_1FFF >> 6, 10, 1'b0, cap);
      pulse_upd();
      chk("R4", "code_a after short frame", code_a, 12'h123);
      chk("R4", "code_b after short frame", code_b, 12'h0C7);
   endtask

   task automatic t_unknown();
      send(16'hEABC);
      send(16'h0F0F);
      send(16'h6555);
      pulse_upd();
      chk("R11", "code_a after unused commands", code_a, 12'h123);
      chk("R11", "code_b after unused commands", code_b, 12'h0C7);
   endtask

   task automatic t_readback();
      logic [15:0] got;
      upd_n = 1'b0;
      pause(HOLD);
      send(16'h29E1);
      chk("R6", "code_b auto", code_b, 12'h9E1);
      read_back(16'h4000, got);
      chk("R8", "readback B", got, 16'h09E1);
      read_back(16'h3000, got);
      chk("R8", "readback A", got, 16'h0123);
   endtask

   task automatic t_edge();
      logic [15:0] got;
      send(16'h5001);
      rise_mode = 1'b1;
      send(16'h13C5);
      chk("R7", "code_a rising sampling", code_a, 12'h3C5);
      read_back(16'h3000, got);
      chk("R7 R8", "readback A rising sampling", got, 16'h03C5);
      send(16'h5000);
      rise_mode = 1'b0;
      send(16'h2111);
      chk("R7", "code_b falling sampling again", code_b, 12'h111);
   endtask

   task automatic t_clear();
      clear_n = 1'b0;
      pause(HOLD);
      chk("R9", "code_a zero clear", code_a, 12'h000);
      chk("R9", "code_b zero clear", code_b, 12'h000);
      clear_n = 1'b1;
      pause(HOLD);
      send(16'h5002);
      upd_n = 1'b1;
      pause(HOLD);
      clear_n = 1'b0;
      pause(HOLD);
      clear_n = 1'b1;
      pause(HOLD);
      chk("R9", "code_a midscale clear", code_a, 12'h800);
      chk("R9", "code_b midscale clear", code_b, 12'h800);
      pulse_upd();
      chk("R9", "input A cleared too", code_a, 12'h800);
   endtask

   task automatic t_daisy();
      logic [31:0] cap;
      upd_n = 1'b0;
      pause(HOLD);
      send(16'h5006);
      send_bits(32'h2ABC_1456, 32, 1'b0, cap);
      chk("R10", "pass-through word", cap[15:0], 16'h2ABC);
      chk("R10", "last word decoded", code_a, 12'h456);
      chk("R10", "first word not decoded", code_b, 12'h800);
      send_bits(32'h0000_0017, 8, 1'b0, cap);
      chk("R10", "short chained frame", code_a, 12'h456);
      send_bits(32'h0000_2DEF, 16, 1'b1, cap);
      chk("R10", "no decode before frame end", code_b, 12'h800);
      close_frame();
      chk("R10", "decode at frame end", code_b, 12'hDEF);
      send(16'h5002);
      send_bits(32'h0000_10AA, 16, 1'b1, cap);
      chk("R3 R6", "standalone update at 16th edge", code_a, 12'h0AA);
      close_frame();
      chk("R3", "code_a after frame end", code_a, 12'h0AA);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      pause(5);
      rst_n = 1'b1;
      pause(HOLD);
      t_reset();
      t_write_hold();
      t_auto();
      t_partial();
      t_unknown();
      t_readback();
      t_edge();
      t_clear();
      t_daisy();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule